// File: doc/BRIEF.md
# Prefixed Vector Instruction Sequencer

This block sits beside instruction fetch. It looks at the 32-bit word fetched at the current PC and decides whether that word is a vector prefix. When it is, the block extracts the 24-bit remap field that the prefix carries. The instruction that follows the prefix, at PC+4, is the suffix that actually executes.

The block also runs the element loop that turns one prefixed instruction into several element operations. A 32-bit vector-state register holds the vector length and the element counters. Each completion strobe from the pipeline is one element finishing. While the destination is a vector and elements remain, the block holds the next PC at the current PC and advances the source element counter. After the last element, or when the destination is scalar, the counter clears and the PC moves past the prefix/suffix pair. A prefixed instruction with a vector length of zero is skipped outright.

A three-state machine records the outcome of the most recent completion:
- `SEQ_RUN`: the PC advanced. This is the reset state.
- `SEQ_HOLD`: the PC was held to run another element.
- `SEQ_SKIP`: the instruction was skipped because the vector length was zero.

On every completion strobe the machine takes exactly one transition, from any state:
- to `SEQ_SKIP` when the word is a prefix and VL = 0;
- to `SEQ_HOLD` when the word is a prefix, VL ≠ 0, the destination is a vector, and the source step ≠ VL−1;
- to `SEQ_RUN` in every other case.

Without a strobe the machine stays in its state.

Top module: `vpfx_seq`

## Requirements
- R1: `pfx_mode` is 1, combinationally, exactly when `insn_word[31:26]` = 6'b000001, `insn_word[24]` = 1 and `insn_word[22]` = 1. These are major-opcode bits 0–5 and bits 7 and 9 in MSB-0 numbering.
- R2: `remap` equals {`insn_word[25]`, `insn_word[23]`, `insn_word[21:0]`}, combinationally, whatever the value of `pfx_mode`.
- R3: The state register has these fields:
  - `st_q[31:25]`: maximum vector length
  - `st_q[24:18]`: VL
  - `st_q[17:11]`: source step
  - `st_q[10:4]`: destination step
  - `st_q[3:2]`: sub-vector length
  - `st_q[1:0]`: step kind

  A write with `st_we` loads `st_wdata` at the next edge. A write takes priority over a loop update in the same cycle.
- R4: After reset, `st_q`, `next_pc` and `skip` are all 0.
- R5: On a completion of a non-prefix word, one cycle later `next_pc` = `cur_pc`+4, `skip` = 0 and `st_q` is unchanged.
- R6: On a completion of a prefix word with VL = 0, one cycle later `skip` = 1, `next_pc` = `cur_pc`+8 and `st_q` is unchanged.
- R7: On a completion of a prefix word with VL ≠ 0, `dest_vec` = 1 and source step ≠ VL−1, one cycle later `next_pc` = `cur_pc` and the source step has increased by 1.
- R8: On a completion of a prefix word with VL ≠ 0 where either the source step = VL−1 or `dest_vec` = 0, one cycle later the source step is 0, `next_pc` = `cur_pc`+8 and `skip` = 0.
- R9: Between completion strobes, `next_pc` and `skip` hold their values regardless of changes on `insn_word`, `cur_pc` or `dest_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_word | input | 32 | Word fetched at the current PC |
| cur_pc | input | PC_W | Current PC |
| dest_vec | input | 1 | Destination operand is a vector (from decode) |
| insn_done | input | 1 | Instruction/element completion strobe |
| st_we | input | 1 | Vector-state write enable |
| st_wdata | input | 32 | Vector-state write data |
| remap | output | 24 | Remap field extracted from the word |
| pfx_mode | output | 1 | Word is a vector prefix |
| skip | output | 1 | Last completed prefixed instruction was skipped |
| next_pc | output | PC_W | Next PC from the last completion |
| st_q | output | 32 | Current vector-state register |

## Verification
A corrupted sequencer state or source counter shows up at the ports one cycle after the completion strobe that follows it:
- A loop counter off by one ends the element loop a strobe early or late. That appears as `next_pc` jumping by 8 where it should have repeated `cur_pc`, or the reverse, and as a source-step field in `st_q` that differs from the count of held completions.
- A wrong state encoding appears as `skip` raised outside a zero-length prefixed instruction.
- An output register that loads without a strobe appears as `next_pc` drifting while the bench changes `cur_pc` between completions.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
    localparam int WORD_W  = 32;
    localparam int OPC_W   = 6;
    localparam int FLD_W   = 7;
    localparam int SUB_W   = 2;
    localparam int REMAP_W = 24;
    // MSB-0 positions of the two marker bits inside the prefix word
    localparam int MARK_A  = 7;
    localparam int MARK_B  = 9;
    // MSB-0 positions of the two scattered remap bits
    localparam int RMP_HI  = 6;
    localparam int RMP_MID = 8;
    localparam int RMP_LOW_W = REMAP_W - 2;
    localparam logic [OPC_W-1:0] PFX_OPC = 6'b000001;

    // field order follows the MSB-0 layout, first field at the top bits
    typedef struct packed {
        logic [FLD_W-1:0] max_len;
        logic [FLD_W-1:0] vlen;
        logic [FLD_W-1:0] src_step;
        logic [FLD_W-1:0] dst_step;
        logic [SUB_W-1:0] sub_len;
        logic [SUB_W-1:0] step_kind;
    } vstate_t;

    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_SKIP = 2'd2
    } seq_state_e;
endpackage

// File: rtl/vpfx_detect.sv
module vpfx_detect
    import vpfx_pkg::*;
(
    input  logic [WORD_W-1:0]  word_i,
    output logic               is_pfx_o,
    output logic [REMAP_W-1:0] remap_o
);
    localparam int TOP = WORD_W - 1;

    logic opc_hit;
    assign opc_hit  = (word_i[TOP -: OPC_W] == PFX_OPC);
    assign is_pfx_o = opc_hit && word_i[TOP - MARK_A] && word_i[TOP - MARK_B];

    assign remap_o[REMAP_W-1] = word_i[TOP - RMP_HI];
    assign remap_o[REMAP_W-2] = word_i[TOP - RMP_MID];

    // contiguous tail of the remap field: low word bits map straight through
    for (genvar k = 0; k < RMP_LOW_W; k++) begin : g_low
        assign remap_o[k] = word_i[k];
    end
endmodule

// File: rtl/vpfx_state.sv
module vpfx_state
    import vpfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              step_inc,
    input  logic              step_clr,
    output vstate_t           st_o
);
    vstate_t st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (wr_en) begin
            st_q <= vstate_t'(wr_data);
        end else if (step_inc) begin
            st_q.src_step <= st_q.src_step + FLD_W'(1);
        end else if (step_clr) begin
            st_q.src_step <= '0;
        end
    end

    assign st_o = st_q;
endmodule

// File: rtl/vpfx_fsm.sv
module vpfx_fsm
    import vpfx_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic             is_pfx_i,
    input  logic             dest_vec_i,
    input  logic [FLD_W-1:0] vlen_i,
    input  logic [FLD_W-1:0] src_step_i,
    input  logic [PC_W-1:0]  cur_pc_i,
    output logic             step_inc_o,
    output logic             step_clr_o,
    output logic             skip_o,
    output logic [PC_W-1:0]  next_pc_o
);
    localparam logic [PC_W-1:0] STEP_SHORT = PC_W'(4);
    localparam logic [PC_W-1:0] STEP_LONG  = PC_W'(8);

    seq_state_e      state_q, state_d, verdict;
    logic [PC_W-1:0] target;
    logic            want_inc, want_clr;
    logic            more_elems;

    assign more_elems = (src_step_i != FLD_W'(vlen_i - FLD_W'(1)));

    // classify the completing instruction
    always_comb begin
        verdict  = SEQ_RUN;
        target   = cur_pc_i + STEP_SHORT;
        want_inc = 1'b0;
        want_clr = 1'b0;
        if (is_pfx_i) begin
            if (vlen_i == '0) begin
                verdict = SEQ_SKIP;
                target  = cur_pc_i + STEP_LONG;
            end else if (dest_vec_i && more_elems) begin
                verdict  = SEQ_HOLD;
                target   = cur_pc_i;
                want_inc = 1'b1;
            end else begin
                verdict  = SEQ_RUN;
                target   = cur_pc_i + STEP_LONG;
                want_clr = 1'b1;
            end
        end
    end

    assign state_d    = done_i ? verdict : state_q;
    assign step_inc_o = done_i && want_inc;
    assign step_clr_o = done_i && want_clr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // registered PC output, loaded only on a completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o <= '0;
        end else if (done_i) begin
            next_pc_o <= target;
        end
    end

    always_comb begin
        skip_o = 1'b0;
        unique case (state_q)
            SEQ_RUN:  skip_o = 1'b0;
            SEQ_HOLD: skip_o = 1'b0;
            SEQ_SKIP: skip_o = 1'b1;
            default:  skip_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/vpfx_seq.sv
module vpfx_seq
    import vpfx_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  insn_word,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic               dest_vec,
    input  logic               insn_done,
    input  logic               st_we,
    input  logic [WORD_W-1:0]  st_wdata,
    output logic [REMAP_W-1:0] remap,
    output logic               pfx_mode,
    output logic               skip,
    output logic [PC_W-1:0]    next_pc,
    output logic [WORD_W-1:0]  st_q
);
    vstate_t st;
    logic    step_inc, step_clr;

    vpfx_detect u_detect (
        .word_i   (insn_word),
        .is_pfx_o (pfx_mode),
        .remap_o  (remap)
    );

    vpfx_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_we),
        .wr_data  (st_wdata),
        .step_inc (step_inc),
        .step_clr (step_clr),
        .st_o     (st)
    );

    vpfx_fsm #(.PC_W(PC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (insn_done),
        .is_pfx_i   (pfx_mode),
        .dest_vec_i (dest_vec),
        .vlen_i     (st.vlen),
        .src_step_i (st.src_step),
        .cur_pc_i   (cur_pc),
        .step_inc_o (step_inc),
        .step_clr_o (step_clr),
        .skip_o     (skip),
        .next_pc_o  (next_pc)
    );

    assign st_q = st;
endmodule

// File: rtl/vpfx_seq_chk.sv
module vpfx_seq_chk #(
    parameter int PC_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [31:0]     insn_word,
    input logic [PC_W-1:0] cur_pc,
    input logic            dest_vec,
    input logic            insn_done,
    input logic            st_we,
    input logic [31:0]     st_wdata,
    input logic            pfx_mode,
    input logic            skip,
    input logic [PC_W-1:0] next_pc,
    input logic [31:0]     st_q
);
    logic [6:0] vl, ss;
    logic       go_on;

    assign vl    = st_q[24:18];
    assign ss    = st_q[17:11];
    assign go_on = dest_vec && (ss != vl - 7'd1);

    AST_VL0_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && pfx_mode && vl == 7'd0 |=> skip);  // R6

    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && pfx_mode && vl != 7'd0 && go_on |=> next_pc == $past(cur_pc));  // R7

    AST_LOOP_END: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && pfx_mode && vl != 7'd0 && !go_on && !st_we
        |=> st_q[17:11] == 7'd0 && next_pc == $past(cur_pc) + PC_W'(8));  // R8

    AST_SCALAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && !pfx_mode |=> next_pc == $past(cur_pc) + PC_W'(4) && !skip);  // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_done |=> $stable(next_pc) && $stable(skip));  // R9

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> st_q == $past(st_wdata));  // R3
endmodule

bind vpfx_seq vpfx_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_word (insn_word),
    .cur_pc    (cur_pc),
    .dest_vec  (dest_vec),
    .insn_done (insn_done),
    .st_we     (st_we),
    .st_wdata  (st_wdata),
    .pfx_mode  (pfx_mode),
    .skip      (skip),
    .next_pc   (next_pc),
    .st_q      (st_q)
);

// File: tb/tb_vpfx_seq.sv
`timescale 1ns/1ps
module tb_vpfx_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] insn_word;
    logic [63:0] cur_pc;
    logic        dest_vec, insn_done, st_we;
    logic [31:0] st_wdata;
    logic [23:0] remap;
    logic        pfx_mode, skip;
    logic [63:0] next_pc;
    logic [31:0] st_q;

    always #10 clk = ~clk;

    vpfx_seq dut (
        .clk(clk), .rst_n(rst_n), .insn_word(insn_word), .cur_pc(cur_pc),
        .dest_vec(dest_vec), .insn_done(insn_done), .st_we(st_we),
        .st_wdata(st_wdata), .remap(remap), .pfx_mode(pfx_mode), .skip(skip),
        .next_pc(next_pc), .st_q(st_q)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [63:0] pc;
        logic        sk;
        logic [31:0] st;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_st;
    logic        chk_due;
    logic [63:0] last_pc;
    logic        last_sk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [6:0] mx, logic [6:0] vl, logic [6:0] ss,
                                       logic [6:0] ds, logic [1:0] sb_, logic [1:0] sk);
        return {mx, vl, ss, ds, sb_, sk};
    endfunction

    function automatic logic [31:0] word(logic [5:0] opc, logic b6, logic b7,
                                         logic b8, logic b9, logic [21:0] low);
        return {opc, b6, b7, b8, b9, low};
    endfunction

    // monitor: compare one cycle after each completion strobe
    always @(posedge clk) chk_due <= insn_done;

    always @(negedge clk) begin
        if (rst_n && chk_due) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL scoreboard empty actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " next_pc"}, next_pc, e.pc);
                check({e.tag, " skip"}, {63'd0, skip}, {63'd0, e.sk});
                check({e.tag, " st_q"}, {32'd0, st_q}, {32'd0, e.st});
                last_pc = e.pc;
                last_sk = e.sk;
            end
        end
    end

    task automatic complete(logic [31:0] w, logic [63:0] pc, logic dv, string tag,
                            logic we = 1'b0, logic [31:0] wd = 32'd0);
        exp_t       e;
        logic       p;
        logic [6:0] vl, ss;
        p  = (w[31:26] == 6'b000001) && w[24] && w[22];
        vl = m_st[24:18];
        ss = m_st[17:11];
        e.st = m_st;
        e.sk = 1'b0;
        e.tag = tag;
        if (!p) begin
            e.pc = pc + 64'd4;
        end else if (vl == 7'd0) begin
            e.pc = pc + 64'd8;
            e.sk = 1'b1;
        end else if (dv && ss != vl - 7'd1) begin
            e.pc = pc;
            e.st[17:11] = ss + 7'd1;
        end else begin
            e.pc = pc + 64'd8;
            e.st[17:11] = 7'd0;
        end
        if (we) e.st = wd;
        m_st = e.st;
        sb.push_back(e);
        @(negedge clk);
        insn_word = w; cur_pc = pc; dest_vec = dv; insn_done = 1'b1;
        st_we = we; st_wdata = wd;
        @(negedge clk);
        insn_done = 1'b0; st_we = 1'b0;
    endtask

    task automatic load(logic [31:0] v);
        @(negedge clk);
        st_we = 1'b1; st_wdata = v;
        @(negedge clk);
        st_we = 1'b0;
        m_st = v;
        check("R3 load", {32'd0, st_q}, {32'd0, v});
    endtask

    task automatic comb_chk(logic [31:0] w, logic exp_p);
        @(negedge clk);
        insn_word = w;
        #1;
        check("R1 prefix detect", {63'd0, pfx_mode}, {63'd0, exp_p});
        check("R2 remap field", {40'd0, remap}, {40'd0, w[25], w[23], w[21:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pw;
        logic [31:0] sw;
        rst_n = 1'b0; insn_word = '0; cur_pc = '0; dest_vec = 1'b0;
        insn_done = 1'b0; st_we = 1'b0; st_wdata = '0; m_st = '0;
        chk_due = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset st_q", {32'd0, st_q}, 64'd0);
        check("R4 reset next_pc", next_pc, 64'd0);
        check("R4 reset skip", {63'd0, skip}, 64'd0);

        comb_chk(word(6'b000001, 1, 1, 0, 1, 22'h3A5C3C), 1'b1);
        comb_chk(word(6'b000001, 0, 1, 1, 1, 22'h00F0F1), 1'b1);
        comb_chk(word(6'b000001, 1, 1, 1, 0, 22'h155555), 1'b0);
        comb_chk(word(6'b000001, 1, 0, 1, 1, 22'h2AAAAA), 1'b0);
        comb_chk(word(6'b000011, 1, 1, 1, 1, 22'h000001), 1'b0);

        pw = word(6'b000001, 1, 1, 0, 1, 22'h012345);
        sw = word(6'b011111, 0, 0, 0, 0, 22'h000214);

        complete(sw, 64'h1000, 1'b0, "R5 scalar word");

        load(mk(7'd8, 7'd0, 7'd0, 7'd0, 2'd0, 2'd0));
        complete(pw, 64'h2000, 1'b1, "R6 zero length skip");

        load(mk(7'd8, 7'd3, 7'd0, 7'd0, 2'd0, 2'd0));
        complete(pw, 64'h3000, 1'b1, "R7 hold element 0");
        complete(pw, 64'h3000, 1'b1, "R7 hold element 1");
        complete(pw, 64'h3000, 1'b1, "R8 last element");

        load(mk(7'd8, 7'd3, 7'd1, 7'd0, 2'd0, 2'd0));
        complete(pw, 64'h3100, 1'b0, "R8 scalar destination");

        load(mk(7'd8, 7'd4, 7'd2, 7'd5, 2'd1, 2'd2));
        complete(sw, 64'h4000, 1'b1, "R5 state untouched");

        complete(pw, 64'h4800, 1'b1, "R7 hold before idle");
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            insn_word = sw ^ 32'(i);
            cur_pc = 64'h9000 + 64'(i * 16);
            dest_vec = i[0];
            @(negedge clk);
            check("R9 next_pc stable", next_pc, last_pc);
            check("R9 skip stable", {63'd0, skip}, {63'd0, last_sk});
        end

        complete(pw, 64'h5000, 1'b1, "R3 write wins",
                 1'b1, mk(7'd9, 7'd5, 7'd0, 7'd0, 2'd0, 2'd0));
        complete(pw, 64'h5000, 1'b1, "R7 after write");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule